// File: doc/BRIEF.md
# CMI Line Encoder with Test Violation Insertion

This block turns a serial NRZ bit stream into a line signal that runs at twice the bit rate. It runs on a half-bit clock. A one-cycle strobe marks each new input bit, and the block then emits two half-bit symbols for that bit on consecutive clock cycles. A mode input picks one of two outputs. The first is Coded Mark Inversion, where a zero becomes a low-then-high pair and each one becomes a full bit held at a level that alternates from mark to mark. The second is a plain NRZ pass-through, where each bit is simply repeated in both halves.

A test input lets line-monitoring equipment be exercised. Each rising edge of this input arms a single code violation. The violation is applied to the next mark, which is sent at the same level as the mark before it, so the alternation rule is broken exactly once. A flag output tells the clocking logic whether the line is running at double rate (CMI) or at the bit rate (NRZ).

Top module: `cmi_line_encoder`

## Requirements
- R1: During and directly after synchronous reset, `line_out` and `double_rate` are 0 and nothing is armed. The first mark sent in CMI mode after reset goes out high.
- R2: When `bit_stb` is high at a clock edge, `line_out` shows the first half-symbol of `bit_in` after that edge and the second half-symbol after the next edge. On every edge without a strobe, `line_out` holds the second half-symbol of the last bit.
- R3: In CMI mode (`nrz_mode` = 0), a 0 bit is sent as 0 in the first half and 1 in the second half.
- R4: In CMI mode, a 1 bit is sent at one level for both halves. The level alternates from one mark to the next, and 0 bits in between do not change it.
- R5: In NRZ mode (`nrz_mode` = 1), each bit appears unchanged in both halves, and the mark alternation state is held for use when CMI mode resumes.
- R6: `double_rate` equals the inverse of `nrz_mode`, registered one clock edge later.
- R7: A rising edge of `viol_req` in CMI mode arms one violation. The next 1 bit is sent at the level of the previous mark. The alternation state is left unchanged, so the mark after that takes the opposite level. Any 0 bits in between are encoded normally.
- R8: Rising edges of `viol_req` that arrive while a violation is armed, and a request held high, produce no additional violation.
- R9: In NRZ mode, `viol_req` has no effect. Edges seen there arm nothing, and entering NRZ mode discards an armed violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | New-bit strobe, one cycle per bit |
| bit_in | input | 1 | NRZ data bit, sampled with the strobe |
| nrz_mode | input | 1 | 1 = NRZ pass-through, 0 = CMI encoding |
| viol_req | input | 1 | Rising edge requests one code violation |
| line_out | output | 1 | Encoded half-bit line signal |
| double_rate | output | 1 | 1 while the line runs at twice the bit rate |

## Verification
A wrong alternation register shows up on the very next mark, which then leaves at the wrong level. The fault also persists, so every later mark is inverted until another error cancels it. A stuck or leaky armed flag is different: it shows either as a mark that never repeats the previous level after a request, or as repeated marks on later ones. Both appear within one or two bits of the request. The bench compares every half-symbol against an arithmetic model across all 8-bit patterns, so a swapped half or a missing hold appears in the cycle it occurs.

// File: rtl/cmi_enc_pkg.sv
package cmi_enc_pkg;
  // Pair of half-bit symbols emitted for one input bit
  typedef struct packed {
    logic first;
    logic second;
  } halves_t;

  // Level used for a 0 bit in CMI, per half
  localparam logic ZERO_FIRST  = 1'b0;
  localparam logic ZERO_SECOND = 1'b1;
endpackage

// File: rtl/cmi_viol_ctl.sv
module cmi_viol_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic enable,
  input  logic apply,
  output logic pending
);
  logic req_q;
  logic pend_q;
  logic req_rise;

  assign req_rise = req & ~req_q;
  assign pending  = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req;
      if (!enable)
        pend_q <= 1'b0;
      else if (apply)
        pend_q <= 1'b0;
      else if (req_rise)
        pend_q <= 1'b1;
    end
  end

  // R8: an armed violation survives extra edges until consumed
  assert_hold_armed_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !apply && enable) |=> pend_q);
  // R8: consuming the violation disarms it
  assert_single_use_R8: assert property (@(posedge clk) disable iff (rst)
    apply |=> !pend_q);
  // R9: nothing stays armed in NRZ mode
  assert_nrz_disarm_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pend_q);
endmodule

// File: rtl/cmi_symbol_map.sv
module cmi_symbol_map
  import cmi_enc_pkg::*;
(
  input  logic    bit_val,
  input  logic    nrz,
  input  logic    mark_lvl,
  input  logic    viol_armed,
  output halves_t sym,
  output logic    mark_nxt,
  output logic    consume
);
  always_comb begin
    sym      = '{first: bit_val, second: bit_val};
    mark_nxt = mark_lvl;
    consume  = 1'b0;
    if (!nrz) begin
      if (!bit_val) begin
        sym = '{first: ZERO_FIRST, second: ZERO_SECOND};
      end else if (viol_armed) begin
        // repeat the previous mark level, keep alternation state
        sym     = '{first: ~mark_lvl, second: ~mark_lvl};
        consume = 1'b1;
      end else begin
        sym      = '{first: mark_lvl, second: mark_lvl};
        mark_nxt = ~mark_lvl;
      end
    end
  end
endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder
  import cmi_enc_pkg::*;
#(
  parameter logic FIRST_MARK_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic bit_in,
  input  logic nrz_mode,
  input  logic viol_req,
  output logic line_out,
  output logic double_rate
);
  halves_t sym;
  logic    mark_q;
  logic    mark_nxt;
  logic    consume;
  logic    armed;
  logic    half2_q;

  cmi_viol_ctl u_viol (
    .clk     (clk),
    .rst     (rst),
    .req     (viol_req),
    .enable  (~nrz_mode),
    .apply   (bit_stb & consume),
    .pending (armed)
  );

  cmi_symbol_map u_map (
    .bit_val    (bit_in),
    .nrz        (nrz_mode),
    .mark_lvl   (mark_q),
    .viol_armed (armed),
    .sym        (sym),
    .mark_nxt   (mark_nxt),
    .consume    (consume)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q      <= FIRST_MARK_LEVEL;
      half2_q     <= 1'b0;
      line_out    <= 1'b0;
      double_rate <= 1'b0;
    end else begin
      double_rate <= ~nrz_mode;
      if (bit_stb) begin
        line_out <= sym.first;
        half2_q  <= sym.second;
        mark_q   <= mark_nxt;
      end else begin
        line_out <= half2_q;
      end
    end
  end

  // R3: CMI zero starts low
  assert_zero_low_first_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && !nrz_mode && !bit_in) |=> !line_out);
  // R5: NRZ first half follows the data
  assert_nrz_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && nrz_mode) |=> (line_out == $past(bit_in)));
  // R6: rate flag tracks the mode one edge later
  assert_rate_flag_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (double_rate == !$past(nrz_mode)));
  // R4: a normal mark flips the alternation state
  assert_mark_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && !nrz_mode && bit_in && !armed) |=> (mark_q != $past(mark_q)));
  // R7: a violating mark leaves the alternation state alone
  assert_viol_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && !nrz_mode && bit_in && armed) |=> $stable(mark_q));
  // R2: without a strobe the output holds
  assert_hold_second_R2: assert property (@(posedge clk) disable iff (rst)
    (!bit_stb && !$past(bit_stb)) |=> $stable(line_out));
endmodule

// File: tb/tb_cmi_line_encoder.sv
module tb_cmi_line_encoder;
  logic clk = 1'b0;
  logic rst, bit_stb, bit_in, nrz_mode, viol_req;
  logic line_out, double_rate;
  int   errs = 0;
  int   checks = 0;
  bit   done = 0;

  // bench model state
  logic mark_m, pend_m, nrz_m, last2;

  always #2 clk = ~clk;

  cmi_line_encoder dut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .nrz_mode(nrz_mode), .viol_req(viol_req),
    .line_out(line_out), .double_rate(double_rate)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // called just after a negedge; ends just after a negedge
  task automatic send_bit(input logic b, input string tag);
    logic f, s;
    if (nrz_m) begin
      f = b; s = b;
    end else if (!b) begin
      f = 1'b0; s = 1'b1;
    end else if (pend_m) begin
      f = ~mark_m; s = ~mark_m; pend_m = 1'b0;
    end else begin
      f = mark_m; s = mark_m; mark_m = ~mark_m;
    end
    bit_stb = 1'b1; bit_in = b;
    @(posedge clk); @(negedge clk);
    chk(tag, line_out, f);
    bit_stb = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(tag, line_out, s);
    last2 = s;
  endtask

  task automatic pulse_req();
    viol_req = 1'b1;
    if (!nrz_m) pend_m = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2", line_out, last2);
    viol_req = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    nrz_mode = m; nrz_m = m;
    if (m) pend_m = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6", double_rate, ~m);
    chk("R2", line_out, last2);
  endtask

  initial begin
    rst = 1'b1; bit_stb = 0; bit_in = 0; nrz_mode = 0; viol_req = 0;
    mark_m = 1'b1; pend_m = 0; nrz_m = 0; last2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", line_out, 1'b0);
    chk("R1", double_rate, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6", double_rate, 1'b1);
    chk("R1", line_out, 1'b0);
    // first mark after reset goes high
    send_bit(1'b1, "R1");
    // exhaustive 8-bit CMI sweep
    for (int p = 0; p < 256; p++)
      for (int i = 0; i < 8; i++)
        send_bit(p[i], p[i] ? "R4" : "R3");
    // hold without strobe
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R2", line_out, last2);
    end
    // single violation with zeros in between
    pulse_req();
    send_bit(1'b0, "R7"); send_bit(1'b0, "R7");
    send_bit(1'b1, "R7"); send_bit(1'b1, "R7"); send_bit(1'b1, "R7");
    // extra edges while armed
    pulse_req(); pulse_req(); pulse_req();
    send_bit(1'b1, "R8"); send_bit(1'b1, "R8"); send_bit(1'b1, "R8");
    // request held high
    viol_req = 1'b1; pend_m = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < 4; k++) send_bit(1'b1, "R8");
    viol_req = 1'b0;
    send_bit(1'b1, "R8");
    // NRZ sweep
    set_mode(1'b1);
    for (int p = 0; p < 16; p++)
      for (int i = 0; i < 4; i++)
        send_bit(p[i], "R5");
    pulse_req();
    send_bit(1'b1, "R9");
    // back to CMI: no violation left, alternation resumes
    set_mode(1'b0);
    for (int k = 0; k < 4; k++) send_bit(1'b1, "R9");
    // arm, then NRZ discards it
    pulse_req();
    set_mode(1'b1);
    send_bit(1'b1, "R9");
    set_mode(1'b0);
    send_bit(1'b1, "R9"); send_bit(1'b1, "R9"); send_bit(1'b0, "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule